// File: doc/BRIEF.md
# Write-Once Protected Configuration Register

This block holds two startup configuration bits for a small 8-bit bus: one that turns the system watchdog off and one that keeps a memory region mapped. In normal operation these bits are guarded. After each reset, a window opens that lasts for a fixed number of bus cycles. Inside that window the register takes exactly one write. Writes after that write, or after the window has closed, have no effect. This lets boot code set the configuration once and then locks it against stray stores.

When the special-mode input is high, the guard is bypassed. The register then takes every write, regardless of the cycle count and of earlier writes. A write made in special mode does not use up the single normal-mode write. Moving from special to normal mode never reopens a window that has already closed. Both bits drive dedicated outputs for the watchdog and the address decoder. They also appear at the low end of the read data.

Top module: `cfg_guard_reg`

## Requirements
- R1: While reset is held and right after it, the read data is 0x01, watchdog_disable_o is 0 and mem_enable_o is 1.
- R2: A write request exists only when sel_i, wr_i and addr_hit_i are all high in the same cycle. If any of them is low, the register keeps its contents.
- R3: In normal mode, an accepted write loads wdata_i bit 1 into the watchdog-disable bit and wdata_i bit 0 into the memory-enable bit. The new values are visible one clock after the write.
- R4: In normal mode, only the first write request inside the window is accepted. Every later request before the next reset is ignored.
- R5: The window counts bus_cyc_i pulses from reset and stays open while fewer than 64 have been seen. A write request on the same edge as the 64th pulse is accepted. A write request after 64 pulses is ignored even if no write was made before.
- R6: With special_i high, every write request is accepted, any number of times and at any cycle count.
- R7: Read data bits 7 down to 2 always read 0, whatever is written.
- R8: Writes made with special_i high do not use up the normal-mode write. After switching to normal mode inside the window, one write is still accepted.
- R9: Once the window has closed, clearing special_i does not reopen it, and normal-mode writes stay ignored.
- R10: A reset restores the values in R1, reopens the window and re-arms the single write.
- R11: watchdog_disable_o always equals read data bit 1, and mem_enable_o always equals read data bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| special_i | input | 1 | High in special mode, which bypasses the write guard |
| bus_cyc_i | input | 1 | One pulse per bus cycle, advances the window counter |
| sel_i | input | 1 | Bus select |
| wr_i | input | 1 | Write strobe |
| addr_hit_i | input | 1 | Address matches this register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data: bits 7:2 are zero, bit 1 is watchdog disable, bit 0 is memory enable |
| watchdog_disable_o | output | 1 | 1 turns the watchdog off |
| mem_enable_o | output | 1 | 1 keeps the memory region mapped |

## Verification
The assertions check on every cycle that:
- the unused read bits are zero and both outputs mirror the read data;
- the counter never passes the window length, and a closed window stays closed;
- a normal-mode request made after the write is used or after the window closes leaves the bits unchanged;
- a special-mode request loads the data bits.

Some behaviour only the bench scenarios can show:
- the exact boundary at the 64th bus cycle;
- that special-mode writes leave the normal write still armed;
- that a reset re-arms both the window and the write;
- that a request with one strobe missing is ignored across long random runs.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;
  localparam int unsigned DW        = 8;
  localparam int unsigned NB        = 2;
  localparam int unsigned WD_BIT    = 1;
  localparam int unsigned MEM_BIT   = 0;
  localparam int unsigned WIN_LEN   = 64;
  localparam logic [NB-1:0] RST_VALS = 2'b01;
endpackage

// File: rtl/cfg_window.sv
module cfg_window #(
  parameter int unsigned LEN = 64,
  parameter int unsigned CW  = $clog2(LEN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  output logic          open_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] LIMIT = CW'(LEN);

  logic [CW-1:0] cnt_q;

  assign open_o = (cnt_q < LIMIT);
  assign cnt_o  = cnt_q;

  // saturates at LIMIT
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (tick_i && open_o)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cfg_wo_bit.sv
module cfg_wo_bit #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= RST_VAL;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/cfg_guard_reg.sv
module cfg_guard_reg
  import cfg_guard_pkg::*;
#(
  parameter int unsigned WINDOW = WIN_LEN
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          special_i,
  input  logic          bus_cyc_i,
  input  logic          sel_i,
  input  logic          wr_i,
  input  logic          addr_hit_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          watchdog_disable_o,
  output logic          mem_enable_o
);
  localparam int unsigned CW = $clog2(WINDOW + 1);

  logic          wr_req;
  logic          win_open;
  logic [CW-1:0] win_cnt;
  logic          done_q;
  logic          normal_ok;
  logic          accept;
  logic [NB-1:0] bits;

  assign wr_req    = sel_i & wr_i & addr_hit_i;
  assign normal_ok = win_open & ~done_q;
  assign accept    = wr_req & (special_i | normal_ok);

  cfg_window #(.LEN(WINDOW), .CW(CW)) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (bus_cyc_i),
    .open_o (win_open),
    .cnt_o  (win_cnt)
  );

  // only a normal-mode write consumes the single shot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             done_q <= 1'b0;
    else if (wr_req && !special_i && normal_ok) done_q <= 1'b1;
  end

  for (genvar i = 0; i < NB; i++) begin : g_bit
    cfg_wo_bit #(.RST_VAL(RST_VALS[i])) u_bit (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (accept),
      .d_i    (wdata_i[i]),
      .q_o    (bits[i])
    );
  end

  assign rdata_o            = {{(DW-NB){1'b0}}, bits};
  assign watchdog_disable_o = bits[WD_BIT];
  assign mem_enable_o       = bits[MEM_BIT];
endmodule

// File: rtl/cfg_guard_chk.sv
module cfg_guard_chk
  import cfg_guard_pkg::*;
#(
  parameter int unsigned WINDOW = WIN_LEN,
  parameter int unsigned CW     = $clog2(WINDOW + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          special_i,
  input logic          wr_req,
  input logic          win_open,
  input logic          done_q,
  input logic [CW-1:0] win_cnt,
  input logic [NB-1:0] bits,
  input logic [NB-1:0] wd_low,
  input logic [DW-1:0] rdata_o,
  input logic          watchdog_disable_o,
  input logic          mem_enable_o
);
  // R7
  unimpl_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DW-1:NB] == '0);

  // R11
  out_mirror_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (watchdog_disable_o == rdata_o[WD_BIT]) && (mem_enable_o == rdata_o[MEM_BIT]));

  // R5
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_cnt <= CW'(WINDOW));

  // R9
  win_stays_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_open |=> !win_open);

  // R4
  used_write_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req && !special_i && done_q) |=> $stable(bits));

  // R5
  closed_write_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req && !special_i && !win_open) |=> $stable(bits));

  // R6
  special_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req && special_i) |=> (bits == $past(wd_low)));
endmodule

bind cfg_guard_reg cfg_guard_chk #(.WINDOW(WINDOW), .CW(CW)) u_chk (
  .clk_i              (clk_i),
  .rst_ni             (rst_ni),
  .special_i          (special_i),
  .wr_req             (wr_req),
  .win_open           (win_open),
  .done_q             (done_q),
  .win_cnt            (win_cnt),
  .bits               (bits),
  .wd_low             (wdata_i[1:0]),
  .rdata_o            (rdata_o),
  .watchdog_disable_o (watchdog_disable_o),
  .mem_enable_o       (mem_enable_o)
);

// File: tb/tb_cfg_guard_reg.sv
module tb_cfg_guard_reg;
  localparam int WIN = 64;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       special_i = 1'b0;
  logic       bus_cyc_i = 1'b0;
  logic       sel_i = 1'b0;
  logic       wr_i = 1'b0;
  logic       addr_hit_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       watchdog_disable_o;
  logic       mem_enable_o;

  int n_run  = 0;
  int n_fail = 0;

  int   m_cnt;
  bit   m_done;
  logic m_wd, m_mem;

  cfg_guard_reg dut (.*);

  always #5 clk_i = ~clk_i;

  function automatic logic [7:0] exp_rd();
    return {6'b0, m_wd, m_mem};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    check(req, rdata_o, exp_rd());
    check("R11", {6'b0, watchdog_disable_o, mem_enable_o}, exp_rd());
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    {sel_i, wr_i, addr_hit_i, bus_cyc_i} = '0;
    m_cnt = 0; m_done = 0; m_wd = 0; m_mem = 1;
    #2 check("R1", rdata_o, 8'h01);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // drive one cycle from a negedge, update model at the posedge, check after
  task automatic cyc(bit sp, bit bc, bit s, bit w, bit h, logic [7:0] d, string req);
    bit req_on;
    bit acc;
    @(negedge clk_i);
    special_i = sp; bus_cyc_i = bc; sel_i = s; wr_i = w; addr_hit_i = h; wdata_i = d;
    req_on = s & w & h;
    acc = req_on && (sp || (m_cnt < WIN && !m_done));
    @(posedge clk_i);
    if (acc) begin m_wd = d[1]; m_mem = d[0]; end
    if (req_on && !sp && m_cnt < WIN && !m_done) m_done = 1;
    if (bc && m_cnt < WIN) m_cnt++;
    #2 check_all(req);
  endtask

  task automatic idle(int n, bit sp);
    for (int i = 0; i < n; i++) cyc(sp, 1'b1, 0, 0, 0, 8'h00, "R5");
  endtask

  initial begin : watchdog
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    check_all("R1");

    // R2: partial strobes ignored
    cyc(0, 0, 1, 1, 0, 8'hFE, "R2");
    cyc(0, 0, 1, 0, 1, 8'hFE, "R2");
    cyc(0, 0, 0, 1, 1, 8'hFE, "R2");
    // R3 then R4
    cyc(0, 0, 1, 1, 1, 8'hFE, "R3");
    check("R7", rdata_o, 8'h02);
    cyc(0, 0, 1, 1, 1, 8'h03, "R4");
    check("R4", rdata_o, 8'h02);

    // R10: reset rearms
    do_reset();
    cyc(0, 0, 1, 1, 1, 8'h03, "R10");
    check("R10", rdata_o, 8'h03);

    // R5: write on edge of 64th pulse accepted
    do_reset();
    idle(63, 0);
    cyc(0, 1, 1, 1, 1, 8'h02, "R5");
    check("R5", rdata_o, 8'h02);

    // R5: write after 64 pulses ignored
    do_reset();
    idle(64, 0);
    cyc(0, 0, 1, 1, 1, 8'h02, "R5");
    check("R5", rdata_o, 8'h01);

    // R6 + R9: special writes after close, then normal locked
    cyc(1, 0, 1, 1, 1, 8'h02, "R6");
    cyc(1, 0, 1, 1, 1, 8'hFF, "R6");
    check("R7", rdata_o, 8'h03);
    cyc(0, 0, 1, 1, 1, 8'h00, "R9");
    check("R9", rdata_o, 8'h03);

    // R8: special writes keep the normal shot armed
    do_reset();
    cyc(1, 1, 1, 1, 1, 8'h02, "R8");
    cyc(1, 1, 1, 1, 1, 8'h00, "R8");
    cyc(0, 1, 1, 1, 1, 8'h03, "R8");
    check("R8", rdata_o, 8'h03);
    cyc(0, 1, 1, 1, 1, 8'h00, "R4");

    // random phases
    for (int r = 0; r < 20; r++) begin
      do_reset();
      for (int i = 0; i < 150; i++) begin
        logic [31:0] v;
        v = $urandom;
        cyc((v[2:0] == 0), v[3] | v[4], v[5] | v[6], v[7] | v[8], v[9] | v[10],
            v[23:16], "R2");
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule